// File: doc/BRIEF.md
# Read-Triggered SECDED Scrubbing Controller

This block sits between one requester and a single-port RAM. Each RAM word holds 64 data bits and 8 check bits. Writes from the requester are encoded on their way into the RAM. Every read codeword is checked and corrected on its way back to the requester. A read that finds a correctable fault can also cause the repaired codeword to be written back to the same word. That write-back is enabled only when two control inputs are both set: one enables error detection and one enables scrubbing. Scrubbing happens only as a side effect of demand reads. There is no timer and no background sweep.

Correctable faults are reported on an error-report port as a one-cycle strobe with the 64-bit-aligned byte address. A downstream error-profiling unit can use this port to log repeated faults. Uncorrectable faults are never written back. Each one pulses a response flag and sets a sticky flag, which stays set until reset.

Top module: `ecc_scrub_ctrl`

## Requirements
- R1: A write stores a 72-bit codeword with this layout: data in RAM bits 63:0, Hamming check bit i in RAM bit 64+i (i = 0..6), and overall parity in RAM bit 71. The Hamming code is built as follows. The data bits, in ascending order, take Hamming positions 3..71, skipping powers of two. Check bit i is the XOR of every data bit whose position has bit i set. Overall parity is the XOR of RAM bits 70:0.
- R2: A read accepted at clock edge T gives `rsp_valid` between edges T+1 and T+2 (one RAM cycle). For a clean codeword, `rsp_rdata` equals the stored data and `rsp_ce`, `rsp_ue` and `err_valid` are all low.
- R3: With detection enabled, a codeword with exactly one flipped bit returns the original data with `rsp_ce` high. The flipped bit may be a data bit, a check bit or the overall parity bit.
- R4: With detection enabled, each correctable read pulses `err_valid` in the response cycle. `err_addr` carries the request byte address with bits 2:0 forced to zero.
- R5: With both enables set, a correctable read writes the repaired codeword (data plus freshly computed check bits) to the same word in the response cycle. `req_ready` is low during that cycle.
- R6: With scrubbing disabled, a correctable read still corrects and reports the fault. It writes nothing back, so the RAM word keeps its faulty value, and `req_ready` stays high.
- R7: With detection disabled, `rsp_rdata` is the raw stored data. `rsp_ce`, `rsp_ue` and `err_valid` stay low, and nothing is written back even if scrubbing is enabled.
- R8: With detection enabled, a codeword with two flipped bits gives `rsp_ue` high for exactly the response cycle. It returns the stored data bits unmodified, makes no error report, and leaves the RAM word unchanged.
- R9: `ue_sticky` is low after reset. It goes high with the first uncorrectable read and stays high until reset.
- R10: The RAM is enabled only in the cycle of an accepted request or of a write-back. Idle cycles leave the RAM untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_det_en | input | 1 | Enables checking, correction and reporting |
| scrub_en | input | 1 | Enables write-back of corrected words (needs ecc_det_en) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 64 | Read data (corrected when detection is on) |
| rsp_ce | output | 1 | Response had a corrected single-bit fault |
| rsp_ue | output | 1 | Response had an uncorrectable fault (one-cycle pulse) |
| ue_sticky | output | 1 | Latched uncorrectable-fault flag |
| err_valid | output | 1 | Correctable-fault report strobe |
| err_addr | output | ADDR_W | 64-bit-aligned address of the reported fault |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W-3 | RAM word address |
| ram_wdata | output | 72 | RAM write codeword |
| ram_rdata | input | 72 | RAM read codeword, valid one cycle after a read enable |

## Verification
Every main read path is driven with codewords corrupted in a controlled way:

- **Clean words** show the pass-through and latency.
- **Single flips in the data field** (low, middle and top bit) show that the decoded position points at the right data bit.
- **Single flips of a check bit or the overall parity bit** show correction that leaves the data alone but still repairs the stored word.
- **Double flips** show the uncorrectable path and that no write-back happens.

The same single flip is then read under each setting of the two enables, which separates reporting from repair and from raw pass-through. An unaligned read address shows the low-bit clearing of the reported address.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

  localparam int DATA_W  = 64;
  localparam int HAM_W   = 7;
  localparam int CODE_W  = DATA_W + HAM_W + 1;
  localparam int LAST_POS = DATA_W + HAM_W;   // highest Hamming position (71)

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Check bits: XOR of the positions of all set data bits.
  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= LAST_POS; p++) begin
      if (!is_pow2(p)) begin
        if (d[k]) c = c ^ 7'(p);
        k++;
      end
    end
    return c;
  endfunction

  function automatic logic [CODE_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    c = ham_bits(d);
    return {^{c, d}, c, d};
  endfunction

  // Flip the data bit sitting at Hamming position pos (no-op for check positions).
  function automatic logic [DATA_W-1:0] flip_at(input logic [DATA_W-1:0] d,
                                                input logic [HAM_W-1:0]  pos);
    logic [DATA_W-1:0] r;
    int k;
    r = d;
    k = 0;
    for (int p = 1; p <= LAST_POS; p++) begin
      if (!is_pow2(p)) begin
        if (7'(p) == pos) r[k] = ~r[k];
        k++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ecc_scrub_dec.sv
module ecc_scrub_dec
  import ecc_scrub_pkg::*;
(
  input  logic [CODE_W-1:0] cw,
  output logic [HAM_W-1:0]  syn,
  output logic              par_err,
  output logic              single,
  output logic              double,
  output logic [DATA_W-1:0] cor_data
);

  logic pos_ok;

  always_comb begin
    syn      = cw[DATA_W +: HAM_W] ^ ham_bits(cw[DATA_W-1:0]);
    par_err  = ^cw;
    pos_ok   = int'(syn) <= LAST_POS;
    single   = par_err && pos_ok;
    double   = (!par_err && (syn != '0)) || (par_err && !pos_ok);
    cor_data = single ? flip_at(cw[DATA_W-1:0], syn) : cw[DATA_W-1:0];
  end

  // R3: correction never changes more than one data bit
  always_comb begin
    if (!$isunknown(cw)) begin
      a_r3_one_bit_fix: assert ($countones(cor_data ^ cw[DATA_W-1:0]) <= 1);
    end
  end

endmodule

// File: rtl/ecc_scrub_seq.sv
module ecc_scrub_seq
  import ecc_scrub_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_det_en,
  input  logic              scrub_en,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              single,
  input  logic [DATA_W-1:0] cor_data,
  output logic              req_ready,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-4:0] ram_addr,
  output logic [CODE_W-1:0] ram_wdata,
  output logic              rd_pend,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wb_fire
);

  logic accept;

  assign wb_fire   = rd_pend && ecc_det_en && scrub_en && single;
  assign req_ready = !wb_fire;
  assign accept    = req_valid && req_ready;
  assign ram_en    = accept || wb_fire;
  assign ram_we    = wb_fire || (accept && req_we);
  assign ram_addr  = wb_fire ? rd_addr[ADDR_W-1:3] : req_addr[ADDR_W-1:3];
  assign ram_wdata = ecc_encode(wb_fire ? cor_data : req_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_addr <= '0;
    end else begin
      rd_pend <= accept && !req_we;
      if (accept) rd_addr <= req_addr;
    end
  end

  // R5: a write-back only follows an accepted read
  a_r5_wb_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> $past(req_valid && req_ready && !req_we));

  // R5: write-back targets the word that was read
  a_r5_wb_same_word: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> ram_addr == $past(req_addr[ADDR_W-1:3]));

  // R7: a write not issued by the requester needs both enables
  a_r7_wb_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !(req_valid && req_ready)) |-> (ecc_det_en && scrub_en));

  // R10: no RAM activity without a request or its follow-up
  a_r10_no_idle_access: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> ((req_valid && req_ready) || $past(req_valid && req_ready && !req_we)));

endmodule

// File: rtl/ecc_scrub_err.sv
module ecc_scrub_err #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_pend,
  input  logic              ecc_det_en,
  input  logic              single,
  input  logic              double,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic              ue_pulse,
  output logic              ue_sticky
);

  assign err_valid = rd_pend && ecc_det_en && single;
  assign err_addr  = {rd_addr[ADDR_W-1:3], 3'b000};
  assign ue_pulse  = rd_pend && ecc_det_en && double;

  always_ff @(posedge clk) begin
    if (!rst_n)        ue_sticky <= 1'b0;
    else if (ue_pulse) ue_sticky <= 1'b1;
  end

  // R9: sticky flag never drops without reset
  a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ue_sticky) |-> ue_sticky);

  // R4: reports only in a response cycle with detection on
  a_r4_report_gated: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (ecc_det_en && rd_pend));

  // R8: an uncorrectable read is never reported as correctable
  a_r8_no_report_on_ue: assert property (@(posedge clk) disable iff (!rst_n)
    ue_pulse |-> !err_valid);

endmodule

// File: rtl/ecc_scrub_ctrl.sv
module ecc_scrub_ctrl
  import ecc_scrub_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_det_en,
  input  logic              scrub_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_ce,
  output logic              rsp_ue,
  output logic              ue_sticky,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-4:0] ram_addr,
  output logic [71:0]       ram_wdata,
  input  logic [71:0]       ram_rdata
);

  logic [HAM_W-1:0]  syn;
  logic              par_err, single, double, rd_pend, wb_fire;
  logic [DATA_W-1:0] cor_data;
  logic [ADDR_W-1:0] rd_addr;

  ecc_scrub_dec u_dec (
    .cw(ram_rdata), .syn(syn), .par_err(par_err),
    .single(single), .double(double), .cor_data(cor_data)
  );

  ecc_scrub_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ecc_det_en(ecc_det_en), .scrub_en(scrub_en),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .single(single), .cor_data(cor_data),
    .req_ready(req_ready), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .rd_pend(rd_pend),
    .rd_addr(rd_addr), .wb_fire(wb_fire)
  );

  ecc_scrub_err #(.ADDR_W(ADDR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .rd_pend(rd_pend), .ecc_det_en(ecc_det_en),
    .single(single), .double(double), .rd_addr(rd_addr),
    .err_valid(err_valid), .err_addr(err_addr),
    .ue_pulse(rsp_ue), .ue_sticky(ue_sticky)
  );

  assign rsp_valid = rd_pend;
  assign rsp_rdata = ecc_det_en ? cor_data : ram_rdata[DATA_W-1:0];
  assign rsp_ce    = rd_pend && ecc_det_en && single;

  // R2: a response only follows an accepted read
  a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_we));

endmodule

// File: tb/ecc_scrub_ctrl_test.sv
module ecc_scrub_ctrl_test;

  localparam int AW = 12;
  localparam int WORDS = 1 << (AW - 3);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ecc_det_en = 1'b1, scrub_en = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_ce, rsp_ue, ue_sticky, err_valid;
  logic [63:0] rsp_rdata;
  logic [AW-1:0] err_addr;
  logic ram_en, ram_we;
  logic [AW-4:0] ram_addr;
  logic [71:0] ram_wdata;
  logic [71:0] ram_rdata;
  logic [71:0] mem [WORDS];
  logic inj_en = 1'b0;
  logic [AW-4:0] inj_word = '0;
  logic [71:0] inj_mask = '0;
  logic acc_q;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ecc_scrub_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ecc_det_en(ecc_det_en), .scrub_en(scrub_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_ce(rsp_ce), .rsp_ue(rsp_ue),
    .ue_sticky(ue_sticky), .err_valid(err_valid), .err_addr(err_addr),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // RAM model with fault injection port (single writer process)
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      ram_rdata <= '0;
    end else begin
      if (inj_en) mem[inj_word] <= mem[inj_word] ^ inj_mask;
      if (ram_en && ram_we) mem[ram_addr] <= ram_wdata;
      if (ram_en && !ram_we) ram_rdata <= mem[ram_addr];
    end
  end

  // Reference: place data in a Hamming vector, then take parities per check bit
  function automatic logic [71:0] ref_enc(input logic [63:0] d);
    logic [127:0] h;
    logic [71:0] cw;
    logic b;
    int j;
    h = '0;
    j = 0;
    for (int p = 1; p < 72; p++)
      if ((p & (p - 1)) != 0) begin h[p] = d[j]; j++; end
    cw[63:0] = d;
    for (int i = 0; i < 7; i++) begin
      b = 1'b0;
      for (int p = 1; p < 72; p++) if (((p >> i) & 1) == 1) b = b ^ h[p];
      cw[64+i] = b;
    end
    cw[71] = ^cw[70:0];
    return cw;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [71:0] act,
                     input logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle model of response timing and RAM activity
  always @(posedge clk) begin
    if (!rst_n) acc_q <= 1'b0;
    else acc_q <= req_valid && req_ready && !req_we;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rsp_valid == acc_q, "R2 rsp timing", 72'(rsp_valid), 72'(acc_q));
      chk(!ram_en || (req_valid && req_ready) || acc_q, "R10 idle access",
          72'(ram_en), 72'(0));
      if (!rsp_valid)
        chk(!rsp_ce && !rsp_ue && !err_valid, "R4 flags outside response",
            72'({rsp_ce, rsp_ue, err_valid}), 72'(0));
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    chk(mem[a[AW-1:3]] == ref_enc(d), "R1 stored codeword", mem[a[AW-1:3]], ref_enc(d));
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [71:0] m);
    @(negedge clk);
    inj_en = 1'b1; inj_word = a[AW-1:3]; inj_mask = m;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [63:0] exp_d,
                    input bit exp_ce, input bit exp_ue, input bit exp_wb,
                    input logic [71:0] exp_mem, input bit exp_sticky);
    @(negedge clk);
    chk(req_ready == 1'b1, {req, " ready before read"}, 72'(req_ready), 72'(1));
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {req, " rsp_valid"}, 72'(rsp_valid), 72'(1));
    chk(rsp_rdata == exp_d, {req, " rdata"}, 72'(rsp_rdata), 72'(exp_d));
    chk(rsp_ce == exp_ce, {req, " rsp_ce"}, 72'(rsp_ce), 72'(exp_ce));
    chk(rsp_ue == exp_ue, {req, " rsp_ue"}, 72'(rsp_ue), 72'(exp_ue));
    chk(err_valid == exp_ce, {req, " R4 err_valid"}, 72'(err_valid), 72'(exp_ce));
    if (exp_ce)
      chk(err_addr == {a[AW-1:3], 3'b000}, {req, " R4 err_addr"}, 72'(err_addr),
          72'({a[AW-1:3], 3'b000}));
    chk(req_ready == !exp_wb, {req, " ready in response"}, 72'(req_ready), 72'(!exp_wb));
    chk((ram_en && ram_we) == exp_wb, {req, " write-back"}, 72'(ram_en && ram_we),
        72'(exp_wb));
    @(negedge clk);
    chk(mem[a[AW-1:3]] == exp_mem, {req, " RAM word after"}, mem[a[AW-1:3]], exp_mem);
    chk(rsp_ue == 1'b0, {req, " R8 ue pulse width"}, 72'(rsp_ue), 72'(0));
    chk(ue_sticky == exp_sticky, {req, " R9 ue_sticky"}, 72'(ue_sticky), 72'(exp_sticky));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d1, d2, d3;
    d1 = 64'h0123_4567_89AB_CDEF;
    d2 = 64'hFEDC_0000_1234_5A5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(req_ready && !rsp_valid && !ue_sticky && !err_valid && !ram_en,
        "R9 R10 reset state", 72'({req_ready, rsp_valid, ue_sticky, err_valid, ram_en}),
        72'(5'b10000));

    // R1 R2: clean read, unaligned byte address
    wr(12'h040, d1);
    rd("R2 clean", 12'h045, d1, 0, 0, 0, ref_enc(d1), 0);

    // R3 R4 R5: single data-bit flips at low, middle and top bit
    foreach (d1[i]) begin
      if (i == 0 || i == 31 || i == 63) begin
        d3 = d1 ^ (64'(i) << 8);
        wr(12'h100, d3);
        inject(12'h100, 72'(1) << i);
        rd("R3 R5 data flip", 12'h103, d3, 1, 0, 1, ref_enc(d3), 0);
      end
    end

    // R3 R5: check-bit and overall-parity flips
    inject(12'h040, 72'(1) << 66);
    rd("R3 R5 check flip", 12'h040, d1, 1, 0, 1, ref_enc(d1), 0);
    inject(12'h040, 72'(1) << 71);
    rd("R3 R5 parity flip", 12'h047, d1, 1, 0, 1, ref_enc(d1), 0);

    // R6: scrub off: corrected and reported, not repaired
    scrub_en = 1'b0;
    inject(12'h040, 72'(1) << 40);
    rd("R6 scrub off", 12'h042, d1, 1, 0, 0, ref_enc(d1) ^ (72'(1) << 40), 0);
    scrub_en = 1'b1;
    rd("R5 repair after enable", 12'h040, d1, 1, 0, 1, ref_enc(d1), 0);

    // R7: detect off: raw data, no flags, no write-back
    ecc_det_en = 1'b0;
    inject(12'h040, 72'(1) << 5);
    rd("R7 detect off", 12'h040, d1 ^ 64'h20, 0, 0, 0, ref_enc(d1) ^ 72'h20, 0);
    ecc_det_en = 1'b1;
    rd("R3 detect back on", 12'h040, d1, 1, 0, 1, ref_enc(d1), 0);

    // R8 R9: double flip
    wr(12'h1F8, d2);
    inject(12'h1F8, (72'(1) << 3) | (72'(1) << 50));
    rd("R8 double", 12'h1F9, d2 ^ ((64'(1) << 3) | (64'(1) << 50)), 0, 1, 0,
       ref_enc(d2) ^ ((72'(1) << 3) | (72'(1) << 50)), 1);
    rd("R9 sticky after clean", 12'h040, d1, 0, 0, 0, ref_enc(d1), 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule